// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is a two-address configuration window for a chip-level I/O controller. The lower address holds an index register and the upper address a data register. Software writes an index and then reads or writes the data address to reach one byte of the configuration space. The window stays closed after reset. It opens only when a fixed four-byte key has been written to the index address, and it closes again when software writes a dedicated exit pair.

Inside the window there are chip-wide registers: a logical-device select, a 16-bit identifier and a revision nibble. There are also per-device registers, banked by the selected logical-device number: one activate bit and a 16-bit base address for each device. When the watchdog device is selected, four consecutive indices are not stored here. Their writes and reads are passed to the watchdog block through a strobe, a register select and the data bytes, and that block returns the read data. The watchdog counter itself is outside this block.

Top module: `cfgp_port`

## Requirements
- R1: After reset the window is closed (`cfg_open` low), both addresses read 0xFF, and every activate bit is 0.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index address (`io_addr`=0) opens the window. `cfg_open` rises in the cycle after the fourth byte is written, and not earlier.
- R3: An index byte that does not match the expected key byte restarts key matching. If that byte is 0x87, it counts as the first key byte, so 87 01 87 01 55 55 opens the window and 87 01 55 00 55 does not.
- R4: While the window is closed, writes to the data address (`io_addr`=1) change no state and reach no device, and reads of either address return 0xFF.
- R5: While the window is open, reading the index address returns the last index written.
- R6: Index 0x20 reads the high byte of the chip ID parameter and index 0x21 the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 zero. Writes to these indices have no effect.
- R7: Index 0x07 is the read/write logical-device select. Its value is kept across a close and a reopen.
- R8: Index 0x30 is the activate register of the selected device. A write stores bit 0 only, and the read value is {7'b0, bit}. Bit n of `dev_act` shows device n's activate bit.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) hold a 16-bit base address for each device. Each device keeps its own value.
- R10: When the select is 0x07 (the watchdog device), data accesses to indices 0x71 to 0x74 are forwarded with select values 0 to 3. A data write pulses `wdg_wr` for one cycle with `wdg_wdata` equal to the byte written, and a data read returns `wdg_rdata`. Under any other select these indices pulse nothing and read 0x00.
- R11: Writing index 0x02 and then data 0x02 closes the window, with `cfg_open` falling in the cycle after the data write. A data write of any other value at index 0x02 leaves the window open.
- R12: If the select is NUM_LDN or above, the banked indices read 0x00 and writes to them are ignored. Unmapped indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | Byte write strobe, sampled at the rising edge |
| io_rd | input | 1 | Byte read strobe |
| io_addr | input | 1 | 0 selects the index address, 1 the data address |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte for the current address, combinational |
| cfg_open | output | 1 | High while the configuration window is open |
| dev_act | output | NUM_LDN | Activate bit of each logical device |
| wdg_wr | output | 1 | Forwarded write strobe to the watchdog register bank |
| wdg_rd | output | 1 | Forwarded read strobe to the watchdog register bank |
| wdg_sel | output | WDG_SEL_W | Watchdog register select, 0 for the first index |
| wdg_wdata | output | 8 | Forwarded write byte |
| wdg_rdata | input | 8 | Read byte returned by the watchdog register bank |

## Verification
A wrong key-position counter shows at the ports as `cfg_open` rising one write too early or too late. It is seen on the first port read after the fourth key byte, one cycle after that write. A corrupted index or select register shows on the next data read, as a byte taken from the wrong register or device, or as a `wdg_wr` pulse that should not occur. Banked storage faults stay hidden until that device is selected and read back. For this reason the random phase reads back a random device after every write.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int          KEY_LEN     = 4;
  localparam logic [7:0]  IDX_EXIT    = 8'h02;
  localparam logic [7:0]  EXIT_VAL    = 8'h02;
  localparam logic [7:0]  IDX_LDN     = 8'h07;
  localparam logic [7:0]  IDX_ID_HI   = 8'h20;
  localparam logic [7:0]  IDX_ID_LO   = 8'h21;
  localparam logic [7:0]  IDX_REV     = 8'h22;
  localparam logic [7:0]  IDX_ACT     = 8'h30;
  localparam logic [7:0]  IDX_BASE_HI = 8'h60;
  localparam logic [7:0]  IDX_BASE_LO = 8'h61;
  localparam logic [7:0]  IDX_WDG_0   = 8'h71;
  localparam logic [7:0]  CLOSED_RD   = 8'hFF;

  // expected byte at each position of the unlock key
  function automatic logic [7:0] key_byte(input logic [1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_key_unlock.sv
module cfgp_key_unlock
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       exit_req,
  output logic       open
);
  logic [1:0] pos_q, pos_d;
  logic       open_q, open_d;
  logic       upd;

  always_comb begin
    pos_d  = pos_q;
    open_d = open_q;
    upd    = 1'b0;
    if (open_q) begin
      if (exit_req) begin
        open_d = 1'b0;
        upd    = 1'b1;
      end
      if (pos_q != 2'd0) begin
        pos_d = 2'd0;
        upd   = 1'b1;
      end
    end else if (idx_wr) begin
      upd = 1'b1;
      if (wdata == key_byte(pos_q)) begin
        if (pos_q == 2'(KEY_LEN - 1)) begin
          open_d = 1'b1;
          pos_d  = 2'd0;
        end else begin
          pos_d = pos_q + 2'd1;
        end
      end else if (wdata == key_byte(2'd0)) begin
        pos_d = 2'd1;
      end else begin
        pos_d = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= 2'd0;
      open_q <= 1'b0;
    end else if (upd) begin
      pos_q  <= pos_d;
      open_q <= open_d;
    end
  end

  assign open = open_q;
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
#(
  parameter int NUM_LDN = 16,
  localparam int LDN_W  = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dat_wr,
  input  logic [7:0]         ldn,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic [NUM_LDN-1:0] act,
  output logic [7:0]         rd_data
);
  logic              ldn_ok;
  logic [LDN_W-1:0]  dev;
  logic [15:0]       base_w [NUM_LDN];

  assign ldn_ok = int'(ldn) < NUM_LDN;
  assign dev    = ldn[LDN_W-1:0];

  for (genvar i = 0; i < NUM_LDN; i++) begin : g_dev
    logic        sel;
    logic        act_q;
    logic        act_en;
    logic [15:0] base_q, base_d;
    logic        base_en;

    assign sel     = ldn_ok && (int'(dev) == i);
    assign act_en  = dat_wr && sel && (idx == IDX_ACT);
    assign base_en = dat_wr && sel && ((idx == IDX_BASE_HI) || (idx == IDX_BASE_LO));

    always_comb begin
      base_d = base_q;
      if (idx == IDX_BASE_HI) base_d[15:8] = wdata;
      else                    base_d[7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q  <= 1'b0;
        base_q <= 16'h0000;
      end else begin
        if (act_en)  act_q  <= wdata[0];
        if (base_en) base_q <= base_d;
      end
    end

    assign act[i]    = act_q;
    assign base_w[i] = base_q;
  end

  always_comb begin
    rd_data = 8'h00;
    if (ldn_ok) begin
      case (idx)
        IDX_ACT:     rd_data = {7'b0, act[dev]};
        IDX_BASE_HI: rd_data = base_w[dev][15:8];
        IDX_BASE_LO: rd_data = base_w[dev][7:0];
        default:     rd_data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfgp_wdg_fwd.sv
module cfgp_wdg_fwd
  import cfgp_pkg::*;
#(
  parameter logic [7:0] WDG_LDN  = 8'h07,
  parameter int         WDG_REGS = 4,
  localparam int        SEL_W    = (WDG_REGS > 1) ? $clog2(WDG_REGS) : 1
)(
  input  logic             open,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic             io_addr,
  input  logic [7:0]       ldn,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic [7:0]       ext_rdata,
  output logic             fwd_wr,
  output logic             fwd_rd,
  output logic [SEL_W-1:0] fwd_sel,
  output logic [7:0]       fwd_wdata,
  output logic [7:0]       rd_data
);
  logic in_win;
  logic hit;

  assign in_win = (int'(idx) >= int'(IDX_WDG_0)) && (int'(idx) < int'(IDX_WDG_0) + WDG_REGS);
  assign hit    = open && io_addr && (ldn == WDG_LDN) && in_win;

  assign fwd_wr    = hit && io_wr;
  assign fwd_rd    = hit && io_rd;
  assign fwd_sel   = SEL_W'(idx - IDX_WDG_0);
  assign fwd_wdata = wdata;
  assign rd_data   = hit ? ext_rdata : 8'h00;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int          NUM_LDN   = 16,
  parameter logic [15:0] CHIP_ID   = 16'h5A3C,
  parameter logic [3:0]  CHIP_REV  = 4'h6,
  parameter logic [7:0]  WDG_LDN   = 8'h07,
  parameter int          WDG_REGS  = 4,
  localparam int         WDG_SEL_W = (WDG_REGS > 1) ? $clog2(WDG_REGS) : 1
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic                 io_addr,
  input  logic [7:0]           io_wdata,
  output logic [7:0]           io_rdata,
  output logic                 cfg_open,
  output logic [NUM_LDN-1:0]   dev_act,
  output logic                 wdg_wr,
  output logic                 wdg_rd,
  output logic [WDG_SEL_W-1:0] wdg_sel,
  output logic [7:0]           wdg_wdata,
  input  logic [7:0]           wdg_rdata
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       open;
  logic       idx_wr, dat_wr, exit_req;
  logic [7:0] idx_q, idx_d;
  logic       idx_en;
  logic [7:0] ldn_q;
  logic       ldn_en;
  logic [7:0] bank_rd, wdg_rd_data;

  assign idx_wr   = io_wr && !io_addr;
  assign dat_wr   = open && io_wr && io_addr;
  assign exit_req = dat_wr && (idx_q == IDX_EXIT) && (io_wdata == EXIT_VAL);
  assign ldn_en   = dat_wr && (idx_q == IDX_LDN);

  cfgp_key_unlock i_key (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .exit_req (exit_req),
    .open     (open)
  );

  // index register: cleared while closed, loaded by index writes while open
  always_comb begin
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (!open) begin
      idx_d  = 8'h00;
      idx_en = (idx_q != 8'h00);
    end else if (idx_wr) begin
      idx_d  = io_wdata;
      idx_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) idx_q <= 8'h00;
    else if (idx_en) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ldn_q <= 8'h00;
    else if (ldn_en) ldn_q <= io_wdata;
  end

  cfgp_dev_bank #(.NUM_LDN(NUM_LDN)) i_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dat_wr  (dat_wr),
    .ldn     (ldn_q),
    .idx     (idx_q),
    .wdata   (io_wdata),
    .act     (dev_act),
    .rd_data (bank_rd)
  );

  cfgp_wdg_fwd #(.WDG_LDN(WDG_LDN), .WDG_REGS(WDG_REGS)) i_wdg (
    .open      (open),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .ldn       (ldn_q),
    .idx       (idx_q),
    .wdata     (io_wdata),
    .ext_rdata (wdg_rdata),
    .fwd_wr    (wdg_wr),
    .fwd_rd    (wdg_rd),
    .fwd_sel   (wdg_sel),
    .fwd_wdata (wdg_wdata),
    .rd_data   (wdg_rd_data)
  );

  always_comb begin
    if (!open) begin
      io_rdata = CLOSED_RD;
    end else if (!io_addr) begin
      io_rdata = idx_q;
    end else begin
      case (idx_q)
        IDX_LDN:   io_rdata = ldn_q;
        IDX_ID_HI: io_rdata = CHIP_ID[15:8];
        IDX_ID_LO: io_rdata = CHIP_ID[7:0];
        IDX_REV:   io_rdata = {4'h0, CHIP_REV};
        default:   io_rdata = bank_rd | wdg_rd_data;
      endcase
    end
  end

  assign cfg_open = open;
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
  parameter int NUM_LDN   = 16,
  parameter int WDG_SEL_W = 2
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 io_wr,
  input logic                 io_rd,
  input logic                 io_addr,
  input logic [7:0]           io_wdata,
  input logic [7:0]           io_rdata,
  input logic                 cfg_open,
  input logic [NUM_LDN-1:0]   dev_act,
  input logic                 wdg_wr,
  input logic                 wdg_rd,
  input logic [WDG_SEL_W-1:0] wdg_sel,
  input logic [7:0]           wdg_wdata,
  input logic [7:0]           wdg_rdata
);
  // R2
  key_last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && !io_addr && io_wdata == 8'h55));

  // R11
  exit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_open) |-> $past(io_wr && io_addr && io_wdata == 8'h02));

  // R4
  closed_data_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_wr && io_addr) |=> $stable(dev_act));

  // R4
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> io_rdata == 8'hFF);

  // R10
  wdg_wr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_wr |-> (cfg_open && io_wr && io_addr && wdg_wdata == io_wdata));

  // R10
  wdg_rd_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rd |-> (cfg_open && io_rd && io_addr && io_rdata == wdg_rdata));
endmodule

bind cfgp_port cfgp_port_chk #(.NUM_LDN(NUM_LDN), .WDG_SEL_W(WDG_SEL_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_rdata  (io_rdata),
  .cfg_open  (cfg_open),
  .dev_act   (dev_act),
  .wdg_wr    (wdg_wr),
  .wdg_rd    (wdg_rd),
  .wdg_sel   (wdg_sel),
  .wdg_wdata (wdg_wdata),
  .wdg_rdata (wdg_rdata)
);

// File: tb/test_cfgp_port.sv
`timescale 1ns/1ps
module test_cfgp_port;
  localparam int NL = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_wr, io_rd, io_addr;
  logic [7:0] io_wdata, io_rdata;
  logic       cfg_open;
  logic [NL-1:0] dev_act;
  logic       wdg_wr, wdg_rd;
  logic [1:0] wdg_sel;
  logic [7:0] wdg_wdata, wdg_rdata;

  always #2 clk = ~clk;

  cfgp_port i_cfgp_port (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open), .dev_act(dev_act),
    .wdg_wr(wdg_wr), .wdg_rd(wdg_rd), .wdg_sel(wdg_sel), .wdg_wdata(wdg_wdata),
    .wdg_rdata(wdg_rdata)
  );

  // bench-side watchdog register model
  logic [7:0] wmem [4];
  int         wcnt = 0;
  always @(posedge clk) if (wdg_wr) begin wmem[wdg_sel] <= wdg_wdata; wcnt <= wcnt + 1; end
  assign wdg_rdata = wmem[wdg_sel];

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx); rd(1'b1, v);
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic unlock();
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
  endtask

  task automatic lock();
    wreg(8'h02, 8'h02);
  endtask

  function automatic logic [7:0] kb(input int p);
    return (p == 0) ? 8'h87 : (p == 1) ? 8'h01 : 8'h55;
  endfunction

  // model of key matching from R2/R3
  function automatic int key_step(input int p, input logic [7:0] b, output bit hit);
    hit = 0;
    if (b == kb(p)) begin
      if (p == 3) begin hit = 1; return 0; end
      return p + 1;
    end
    return (b == 8'h87) ? 1 : 0;
  endfunction

  logic [7:0]  m_act  [NL+4];
  logic [15:0] m_base [NL+4];

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int p;
    bit hit, exp_open;
    int w0;
    void'($urandom(32'd1234));
    io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0; rst_n = 1'b0;
    for (int i = 0; i < 4; i++) wmem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 open", cfg_open, 0);
    chk("R1 act", dev_act, 0);
    rd(0, v); chk("R1 idx read", v, 8'hFF);
    rd(1, v); chk("R1 data read", v, 8'hFF);

    // R4 closed data writes ignored
    wr(1, 8'h01); wr(1, 8'hFF);
    chk("R4 act", dev_act, 0);
    chk("R4 no wdg write", wcnt, 0);
    rd(1, v); chk("R4 read", v, 8'hFF);

    // R2 open only after fourth byte
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55);
    chk("R2 three bytes", cfg_open, 0);
    wr(0, 8'h55);
    chk("R2 opened", cfg_open, 1);

    // R11 wrong exit value keeps open, right one closes
    wreg(8'h02, 8'h03);
    chk("R11 wrong value", cfg_open, 1);
    lock();
    chk("R11 closed", cfg_open, 0);

    // R3 restart and 0x87 re-entry
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h00); wr(0, 8'h55);
    chk("R3 broken key", cfg_open, 0);
    wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55);
    chk("R3 before last", cfg_open, 0);
    wr(0, 8'h55);
    chk("R3 re-entry opens", cfg_open, 1);

    // R5 index readback
    wr(0, 8'h61); rd(0, v); chk("R5 index", v, 8'h61);

    // R6 identification
    rreg(8'h20, v); chk("R6 id hi", v, 8'h5A);
    rreg(8'h21, v); chk("R6 id lo", v, 8'h3C);
    rreg(8'h22, v); chk("R6 rev", v, 8'h06);
    wreg(8'h20, 8'h00); rreg(8'h20, v); chk("R6 id read-only", v, 8'h5A);

    // R7 select
    wreg(8'h07, 8'h05); rreg(8'h07, v); chk("R7 select", v, 8'h05);

    // R8 / R9 per-device registers
    wreg(8'h07, 8'h03);
    wreg(8'h30, 8'hFF); rreg(8'h30, v); chk("R8 act read", v, 8'h01);
    chk("R8 dev_act", dev_act, 32'h0008);
    wreg(8'h60, 8'h12); wreg(8'h61, 8'h34);
    rreg(8'h60, v); chk("R9 base hi", v, 8'h12);
    rreg(8'h61, v); chk("R9 base lo", v, 8'h34);
    wreg(8'h07, 8'h04);
    rreg(8'h60, v); chk("R9 other device", v, 8'h00);
    rreg(8'h30, v); chk("R8 other device", v, 8'h00);

    // R12 out-of-range select and unmapped index
    wreg(8'h07, 8'h20);
    wreg(8'h30, 8'h01);
    chk("R12 act unchanged", dev_act, 32'h0008);
    rreg(8'h30, v); chk("R12 act read", v, 8'h00);
    wreg(8'h07, 8'h03);
    rreg(8'h45, v); chk("R12 unmapped", v, 8'h00);

    // R10 watchdog forwarding
    wreg(8'h07, 8'h07);
    w0 = wcnt;
    for (int i = 0; i < 4; i++) wreg(8'(8'h71 + i), 8'(8'hA0 + i));
    chk("R10 write count", wcnt - w0, 4);
    for (int i = 0; i < 4; i++) begin
      rreg(8'(8'h71 + i), v); chk("R10 readback", v, 8'(8'hA0 + i));
    end
    chk("R10 sel2 data", wmem[2], 8'hA2);
    wreg(8'h75, 8'h55); chk("R10 past window", wcnt - w0, 4);
    wreg(8'h07, 8'h06);
    wreg(8'h72, 8'h99);
    chk("R10 other device no strobe", wcnt - w0, 4);
    rreg(8'h72, v); chk("R10 other device read", v, 8'h00);

    // R7 select survives close/reopen
    lock(); unlock();
    rreg(8'h07, v); chk("R7 kept", v, 8'h06);
    lock();

    // random key fuzz (R2, R3, R4, R11)
    p = 0; exp_open = 0;
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 9);
      b = (r < 3) ? 8'h87 : (r < 5) ? 8'h01 : (r < 8) ? 8'h55 : 8'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        wr(1, b);
        chk("R4 fuzz data write", cfg_open, 0);
      end else begin
        wr(0, b);
        p = key_step(p, b, hit);
        exp_open = hit;
        chk("R3 fuzz open", cfg_open, exp_open);
        if (exp_open) begin
          lock();
          chk("R11 fuzz close", cfg_open, 0);
          p = 0; exp_open = 0;
        end
      end
    end

    // random register traffic (R8, R9, R12)
    unlock();
    wreg(8'h07, 8'h03); wreg(8'h30, 8'h00); wreg(8'h60, 8'h00); wreg(8'h61, 8'h00);
    for (int d = 0; d < NL + 4; d++) begin m_act[d] = 0; m_base[d] = 0; end
    for (int n = 0; n < 1200; n++) begin
      int d, op, rdv;
      logic [7:0] b, e;
      logic [15:0] exp_act;
      d = $urandom_range(0, NL + 3);
      op = $urandom_range(0, 2);
      b = 8'($urandom);
      wreg(8'h07, 8'(d));
      if (op == 0) wreg(8'h30, b);
      else if (op == 1) wreg(8'h60, b);
      else wreg(8'h61, b);
      if (d < NL) begin
        if (op == 0) m_act[d] = {7'b0, b[0]};
        else if (op == 1) m_base[d][15:8] = b;
        else m_base[d][7:0] = b;
      end
      rdv = $urandom_range(0, NL + 3);
      op = $urandom_range(0, 2);
      wreg(8'h07, 8'(rdv));
      if (op == 0) begin rreg(8'h30, v); e = m_act[rdv]; end
      else if (op == 1) begin rreg(8'h60, v); e = m_base[rdv][15:8]; end
      else begin rreg(8'h61, v); e = m_base[rdv][7:0]; end
      if (rdv >= NL) e = 8'h00;
      chk(rdv >= NL ? "R12 random" : "R9 random", v, e);
      exp_act = 0;
      for (int k = 0; k < NL; k++) exp_act[k] = m_act[k][0];
      chk("R8 random dev_act", dev_act, exp_act);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule